// File: doc/BRIEF.md
# Open-Drain Identifier Arbitration Transmitter

This block sits on the card side of a shared command line during multi-card identification. It follows the card through its identification states. When a broadcast request for the card identifier arrives while the card is ready, it shifts its 128-bit identifier onto an open-drain line, one bit per clock and most significant bit first. To send a 0 it pulls the line low. To send a 1 it releases the line.

On every bit the card samples the line level in the same bit period. If the card released the line but reads it low, another card has won that bit. The card then stops driving at once, stays ready and waits for the next request. A card that gets through all identifier bits uncontested becomes identified. A card that is later given an address enters stand-by, switches its output to push-pull and takes no further part in the contest.

Commands arrive already decoded as an index and an argument. Command-bit framing and CRC are handled elsewhere.

Top module: `cid_arb_card`

## Requirements
- R1: After a synchronous active-low reset the card state is idle (code 0), the stored address is 0, and both `drive_low` and `push_pull_en` are 0.
- R2: An operating-conditions command (index 1) received in idle moves the card to ready (code 1) when its argument shares at least one set bit with the parameter `VOLT_MASK`. Otherwise it moves the card to inactive (code 4).
- R3: In the inactive state every command is ignored: the state stays 4 and `drive_low` stays 0.
- R4: An identifier request (index 2) received in ready starts transmission in the next cycle. The card sends `card_id` most significant bit first, one bit per clock. In each bit period `drive_low` is 1 for a 0 bit and 0 for a 1 bit.
- R5: If the card sends a 1 but samples `line_in` low at the clock edge that ends that bit period, `drive_low` is 0 from the next cycle on. The state stays ready, and a later index-2 request restarts transmission from the most significant bit.
- R6: When all identifier bits are sent with no mismatch, the state is identified (code 2) from the cycle after the last bit, and the line is released.
- R7: An address command (index 3) received in identified stores argument bits [31:16] as the card address and moves the card to stand-by (code 3).
- R8: In stand-by `push_pull_en` is 1. Index 1, 2 and 3 commands change neither the state nor the address, and `drive_low` stays 0.
- R9: An index-2 request outside ready is ignored, and an index-3 command outside identified is ignored. In both cases state and address are unchanged.
- R10: Commands received while an identifier transmission is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is present |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| card_id | input | 128 | The card's unique identifier, held static |
| line_in | input | 1 | Sampled level of the shared command line |
| drive_low | output | 1 | Pull the command line low |
| push_pull_en | output | 1 | Output stage in push-pull mode |
| card_state | output | 3 | Identification state: 0 idle, 1 ready, 2 identified, 3 stand-by, 4 inactive |
| card_addr | output | 16 | Address stored by the index-3 command |

## Verification
The assertions assume that `line_in` is the wired-AND of this card's release and every other driver. This means the line can never read high while this card pulls it low. They also assume that `card_id` does not change during a transmission. The bench builds `line_in` from the design's own `drive_low` and a modelled rival card that follows the same arbitration rule, so the line is never low without a driver. The bench holds the identifier constant, and each command strobe lasts exactly one cycle.

// File: rtl/cid_arb_pkg.sv
// Package: shared state codes and command indices for the identifier
// arbitration transmitter.
package cid_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READY  = 3'd1,
        ST_IDENT  = 3'd2,
        ST_STBY   = 3'd3,
        ST_INACT  = 3'd4
    } card_state_e;

    localparam int CMD_IDX_W = 6;

    localparam logic [CMD_IDX_W-1:0] CMD_OP_COND  = 6'd1;
    localparam logic [CMD_IDX_W-1:0] CMD_SEND_ID  = 6'd2;
    localparam logic [CMD_IDX_W-1:0] CMD_SET_ADDR = 6'd3;

endpackage

// File: rtl/cid_shift_arb.sv
// Module: cid_shift_arb
// Loads the identifier on start and sends it MSB first, one bit per clock.
// For a 0 bit it pulls the line low; for a 1 bit it releases the line.
// At each edge it compares its own bit with the sampled line level.
// A released bit that reads low is a lost contest, and sending stops.
// Assumes: start is only given while idle; id_value is stable while busy.
module cid_shift_arb #(
    parameter int ID_W = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [ID_W-1:0] id_value,
    input  logic            line_in,
    output logic            drive_low,
    output logic            busy,
    output logic            won,
    output logic            lost
);
    localparam int CNT_W = (ID_W > 1) ? $clog2(ID_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ID_W - 1);

    logic [ID_W-1:0]  shreg;
    logic [CNT_W-1:0] bits_left;
    logic             cur_bit;

    // Bit currently on the line, and the arbitration outcome for this bit
    always_comb begin
        cur_bit   = shreg[ID_W-1];
        drive_low = busy & ~cur_bit;
        lost      = busy & cur_bit & ~line_in;
        won       = busy & ~lost & (bits_left == '0);
    end

    // Shift register, bit counter and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
            busy      <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                shreg     <= id_value;
                bits_left <= LAST_IDX;
                busy      <= 1'b1;
            end
        end else if (lost || bits_left == '0) begin
            busy <= 1'b0;
        end else begin
            shreg     <= shreg << 1;
            bits_left <= bits_left - 1'b1;
        end
    end

    // R5: a lost bit ends transmission at the next edge
    assert_lost_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> (!busy && !drive_low));

    // R4: an uncontested middle bit advances by exactly one position
    assert_bit_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !lost && bits_left != '0) |=> (busy && bits_left == $past(bits_left) - 1'b1));

    // R4: a start strobe loads the full bit count
    assert_start_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && bits_left == LAST_IDX));

endmodule

// File: rtl/cid_card_fsm.sv
// Module: cid_card_fsm
// The card identification state machine and the address register.
// Decoded commands move the card idle -> ready -> identified -> stand-by.
// An incompatible operating-conditions command parks the card in inactive.
// Commands are ignored while a transmission is in progress.
// Assumes: cmd_valid is a single-cycle strobe.
module cid_card_fsm
    import cid_arb_pkg::*;
#(
    parameter int                 ARG_W     = 32,
    parameter int                 ADDR_W    = 16,
    parameter logic [ARG_W-1:0]   VOLT_MASK = 32'h00FF_8000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [CMD_IDX_W-1:0] cmd_index,
    input  logic [ARG_W-1:0]     cmd_arg,
    input  logic                 tx_busy,
    input  logic                 tx_won,
    output logic                 tx_start,
    output card_state_e          state,
    output logic [ADDR_W-1:0]    addr
);
    logic              accept;
    logic              volt_ok;
    logic [ADDR_W-1:0] arg_addr;

    // Command acceptance, voltage-window match and address field extraction
    always_comb begin
        accept   = cmd_valid & ~tx_busy;
        volt_ok  = |(cmd_arg & VOLT_MASK);
        arg_addr = cmd_arg[ARG_W-1 -: ADDR_W];
        tx_start = accept && (cmd_index == CMD_SEND_ID) && (state == ST_READY);
    end

    // State transitions and address capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            addr  <= '0;
        end else if (tx_busy) begin
            if (tx_won) state <= ST_IDENT;
        end else if (accept) begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_index == CMD_OP_COND)
                        state <= volt_ok ? ST_READY : ST_INACT;
                end
                ST_IDENT: begin
                    if (cmd_index == CMD_SET_ADDR) begin
                        addr  <= arg_addr;
                        state <= ST_STBY;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: inactive is permanent until reset
    assert_inactive_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INACT) |=> (state == ST_INACT));

    // R8: stand-by is permanent and keeps its address
    assert_standby_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY) |=> (state == ST_STBY && $stable(addr)));

    // R7: an address command in identified captures the upper argument bits
    assert_addr_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !tx_busy && cmd_index == CMD_SET_ADDR && state == ST_IDENT)
        |=> (state == ST_STBY && addr == $past(cmd_arg[ARG_W-1 -: ADDR_W])));

    // R10: a strobe during transmission leaves the address untouched
    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && tx_busy) |=> $stable(addr));

endmodule

// File: rtl/cid_arb_card.sv
// Module: cid_arb_card (top)
// Card-side participant in open-drain identifier arbitration. It joins the
// state machine to the bit-serial transmitter and selects the output mode.
// Assumes: line_in is the wired-AND of all drivers on the shared line.
module cid_arb_card
    import cid_arb_pkg::*;
#(
    parameter int               ID_W      = 128,
    parameter int               ARG_W     = 32,
    parameter int               ADDR_W    = 16,
    parameter logic [ARG_W-1:0] VOLT_MASK = 32'h00FF_8000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [CMD_IDX_W-1:0] cmd_index,
    input  logic [ARG_W-1:0]     cmd_arg,
    input  logic [ID_W-1:0]      card_id,
    input  logic                 line_in,
    output logic                 drive_low,
    output logic                 push_pull_en,
    output logic [2:0]           card_state,
    output logic [ADDR_W-1:0]    card_addr
);
    logic        tx_start;
    logic        tx_busy;
    logic        tx_won;
    logic        tx_lost;
    card_state_e state;

    cid_card_fsm #(
        .ARG_W     (ARG_W),
        .ADDR_W    (ADDR_W),
        .VOLT_MASK (VOLT_MASK)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_index (cmd_index),
        .cmd_arg   (cmd_arg),
        .tx_busy   (tx_busy),
        .tx_won    (tx_won),
        .tx_start  (tx_start),
        .state     (state),
        .addr      (card_addr)
    );

    cid_shift_arb #(
        .ID_W (ID_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tx_start),
        .id_value  (card_id),
        .line_in   (line_in),
        .drive_low (drive_low),
        .busy      (tx_busy),
        .won       (tx_won),
        .lost      (tx_lost)
    );

    // Output mode and state code presented at the ports
    always_comb begin
        push_pull_en = (state == ST_STBY);
        card_state   = state;
    end

    // R4: the line is only pulled while the card is ready
    assert_pull_only_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> (state == ST_READY));

    // R6: a completed identifier makes the card identified and releases the line
    assert_win_ident_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_won |=> (state == ST_IDENT && !drive_low));

    // R5: a lost contest keeps the card ready
    assert_lost_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lost |=> (state == ST_READY));

    // R8: push-pull mode never coincides with an arbitration pull
    assert_pushpull_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull_en |-> !drive_low);

endmodule

// File: tb/test_cid_arb_card.sv
// Directed bench for cid_arb_card with a modelled rival card on the line.
module test_cid_arb_card;
    localparam int ID_W = 128;
    localparam logic [ID_W-1:0] MY_ID = 128'hA5C3_0F12_3456_789A_BCDE_F011_2233_4455;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [5:0]      cmd_index = '0;
    logic [31:0]     cmd_arg = '0;
    logic            rival_pull = 1'b0;
    logic            line_in;
    logic            drive_low;
    logic            push_pull_en;
    logic [2:0]      card_state;
    logic [15:0]     card_addr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    assign line_in = ~(drive_low | rival_pull);

    cid_arb_card i_cid_arb_card (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_index    (cmd_index),
        .cmd_arg      (cmd_arg),
        .card_id      (MY_ID),
        .line_in      (line_in),
        .drive_low    (drive_low),
        .push_pull_en (push_pull_en),
        .card_state   (card_state),
        .card_addr    (card_addr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One-cycle command strobe; returns at the negedge after it was taken
    task automatic issue_cmd(input logic [5:0] idx, input logic [31:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_index = idx;
        cmd_arg   = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Returns 1 if drive_low was seen high in any of n cycles
    task automatic watch_pull(input int n, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            #1 if (drive_low) seen = 1'b1;
            @(negedge clk);
        end
    endtask

    // Request the identifier and model one rival card bit by bit
    task automatic run_contest(input logic [ID_W-1:0] rival_id, input int inject_at,
                               output bit pattern_ok, output bit dut_lost);
        bit rival_lost = 1'b0;
        bit ln;
        pattern_ok = 1'b1;
        dut_lost   = 1'b0;
        issue_cmd(6'd2, 32'h0);
        for (int i = ID_W - 1; i >= 0; i--) begin
            cmd_valid  = 1'b0;
            rival_pull = !rival_lost && !rival_id[i];
            if (i == inject_at) begin
                cmd_valid = 1'b1;
                cmd_index = 6'd1;
                cmd_arg   = 32'h0;
            end
            #1;
            if (drive_low !== (!dut_lost && !MY_ID[i])) pattern_ok = 1'b0;
            ln = !((!dut_lost && !MY_ID[i]) || rival_pull);
            if (!dut_lost && MY_ID[i] && !ln) dut_lost = 1'b1;
            if (!rival_lost && rival_id[i] && !ln) rival_lost = 1'b1;
            @(negedge clk);
        end
        cmd_valid  = 1'b0;
        rival_pull = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check(card_state == 3'd0, "R1 state", card_state, 0);
        check(card_addr == 16'd0, "R1 addr", card_addr, 0);
        check(!drive_low && !push_pull_en, "R1 outputs", {drive_low, push_pull_en}, 0);
    endtask

    task automatic t_idle_ignores_request();
        bit seen;
        issue_cmd(6'd2, 32'h0);
        watch_pull(4, seen);
        check(card_state == 3'd0, "R9 idle ignores index 2", card_state, 0);
        check(!seen, "R9 no pull in idle", seen, 0);
    endtask

    task automatic t_op_cond_ok();
        issue_cmd(6'd1, 32'h0030_0000);
        #1 check(card_state == 3'd1, "R2 compatible -> ready", card_state, 1);
    endtask

    task automatic t_addr_in_ready();
        issue_cmd(6'd3, 32'h1234_0000);
        #1;
        check(card_state == 3'd1, "R9 index 3 ignored in ready", card_state, 1);
        check(card_addr == 16'd0, "R9 addr unchanged in ready", card_addr, 0);
    endtask

    task automatic t_lose();
        logic [ID_W-1:0] rival = MY_ID;
        bit ok, lostf;
        int pos = -1;
        for (int i = ID_W - 9; i >= 0; i--) if (pos < 0 && MY_ID[i]) pos = i;
        rival[pos] = 1'b0;
        run_contest(rival, -1, ok, lostf);
        check(ok, "R4 bit pattern before loss", ok, 1);
        check(lostf, "R5 model saw loss", lostf, 1);
        #1;
        check(card_state == 3'd1, "R5 stays ready", card_state, 1);
        check(!drive_low, "R5 line released", drive_low, 0);
    endtask

    task automatic t_win_with_inject();
        logic [ID_W-1:0] rival = MY_ID;
        bit ok, lostf;
        int pos = -1;
        for (int i = ID_W - 5; i >= 0; i--) if (pos < 0 && !MY_ID[i]) pos = i;
        rival[pos] = 1'b1;
        run_contest(rival, ID_W - 20, ok, lostf);
        check(ok, "R4 full bit pattern MSB first", ok, 1);
        #1;
        check(card_state == 3'd2, "R6/R10 identified after win", card_state, 2);
        check(!drive_low, "R6 released after last bit", drive_low, 0);
    endtask

    task automatic t_ident_ignores_request();
        bit seen;
        issue_cmd(6'd2, 32'h0);
        watch_pull(4, seen);
        check(card_state == 3'd2 && !seen, "R9 index 2 ignored in identified",
              {seen, card_state}, 2);
    endtask

    task automatic t_assign_addr();
        issue_cmd(6'd3, 32'hBEEF_5555);
        #1;
        check(card_state == 3'd3, "R7 stand-by", card_state, 3);
        check(card_addr == 16'hBEEF, "R7 address", card_addr, 16'hBEEF);
        check(push_pull_en, "R8 push-pull", push_pull_en, 1);
    endtask

    task automatic t_standby_ignores();
        bit seen;
        issue_cmd(6'd2, 32'h0);
        watch_pull(4, seen);
        issue_cmd(6'd3, 32'h1111_0000);
        issue_cmd(6'd1, 32'h0000_0001);
        #1;
        check(!seen, "R8 no pull in stand-by", seen, 0);
        check(card_state == 3'd3, "R8 state kept", card_state, 3);
        check(card_addr == 16'hBEEF, "R8 address kept", card_addr, 16'hBEEF);
    endtask

    task automatic t_inactive();
        bit seen;
        do_reset();
        #1 check(card_state == 3'd0 && card_addr == 16'd0, "R1 second reset", card_state, 0);
        issue_cmd(6'd1, 32'h0000_0080);
        #1 check(card_state == 3'd4, "R2 incompatible -> inactive", card_state, 4);
        issue_cmd(6'd1, 32'h0030_0000);
        issue_cmd(6'd2, 32'h0);
        watch_pull(4, seen);
        check(card_state == 3'd4, "R3 stays inactive", card_state, 4);
        check(!seen, "R3 no pull", seen, 0);
    endtask

    initial begin
        t_reset();
        t_idle_ignores_request();
        t_op_cond_ok();
        t_addr_in_ready();
        t_lose();
        t_win_with_inject();
        t_ident_ignores_request();
        t_assign_addr();
        t_standby_ignores();
        t_inactive();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule